// File: doc/BRIEF.md
# Zero-Address Stack Evaluator

This block is a small stack machine that executes zero-address instructions one at a time. Each instruction arrives on a valid/ready handshake as a two-bit opcode plus a data-memory address. A push loads a word from the data memory onto a private eight-entry operand stack. A pop stores the top word into the data memory and discards it. An add or a multiply consumes the two topmost entries and leaves a single result.

The block drives a simple synchronous memory port. The read strobe, write strobe, address and write data are all presented in the cycle the instruction is accepted. Read data returns one cycle after the read strobe.

Illegal stack use does not stop the block. An operation that would run past either end of the stack is dropped, and a sticky error flag records it until reset.

Top module: `stack_eval`

## Requirements
- R1: After reset, instr_ready is high, overflow_err and underflow_err are low, and the stack is empty, so the first pop reports underflow.
- R2: A push (opcode 2'b00) on a non-full stack raises mem_rd_en with mem_addr equal to instr_addr in the acceptance cycle. instr_ready is low in the following cycle. The word on mem_rdata in that following cycle becomes the new top, and instr_ready is high again one cycle later.
- R3: A pop (opcode 2'b01) on a non-empty stack raises mem_wr_en in the acceptance cycle, with mem_addr equal to instr_addr and mem_wdata equal to the top entry. It removes that entry, and instr_ready stays high.
- R4: An add (opcode 2'b10) with at least two entries replaces the top two entries by their sum modulo 2^16 in one cycle.
- R5: A multiply (opcode 2'b11) with at least two entries replaces the top two entries by the low 16 bits of their product in one cycle.
- R6: The stack holds eight 16-bit entries. Eight pushes are all retained, and later pops return them in reverse order.
- R7: A push on a full stack sets overflow_err. It makes no memory read, keeps instr_ready high and leaves the stack contents unchanged.
- R8: A pop on an empty stack, or an add or multiply with fewer than two entries, sets underflow_err. It makes no memory write and leaves the stack unchanged.
- R9: Once set, either error flag stays set until reset.
- R10: mem_rd_en and mem_wr_en are never high together. Each is high only in the acceptance cycle of a push or a pop respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction present |
| instr_ready | output | 1 | Block can accept an instruction this cycle |
| instr_op | input | 2 | Opcode: 00 push, 01 pop, 10 add, 11 multiply |
| instr_addr | input | AW (8) | Data-memory address for push and pop |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | AW (8) | Memory address |
| mem_wdata | output | DW (16) | Memory write data (top of stack) |
| mem_rdata | input | DW (16) | Memory read data, one cycle after mem_rd_en |
| overflow_err | output | 1 | Sticky push-on-full flag |
| underflow_err | output | 1 | Sticky underflow flag |

## Verification
The following properties are checked on every cycle:
- the two memory strobes never occur together;
- each strobe appears only with an accepted push or pop;
- an accepted push that reads memory drops instr_ready for exactly one cycle;
- the error flags never clear on their own and rise only after an accepted instruction of the matching kind.

Data correctness can only be shown by the bench's scenarios, which predict every memory write from a model stack:
- the values that reach memory;
- last-in-first-out ordering across a full stack;
- modulo arithmetic;
- the fact that a rejected operation leaves the contents intact.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'b00,
    OP_POP  = 2'b01,
    OP_ADD  = 2'b10,
    OP_MUL  = 2'b11
  } stk_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } stk_state_e;
endpackage

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] below_i,
  input  logic [DW-1:0] top_i,
  input  logic          mul_i,
  output logic [DW-1:0] res_o
);
  logic [DW-1:0] sum_w;
  logic [DW-1:0] prod_w;

  // both results wrap to DW bits
  assign sum_w  = below_i + top_i;
  assign prod_w = below_i * top_i;
  assign res_o  = mul_i ? prod_w : sum_w;
endmodule

// File: rtl/stk_regs.sv
module stk_regs #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic [DW-1:0] push_data,
  input  logic          pop_en,
  input  logic          bin_en,
  input  logic [DW-1:0] bin_data,
  output logic [DW-1:0] top_q,
  output logic [DW-1:0] below_q,
  output logic          empty,
  output logic          full,
  output logic          has_two
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    cnt_d;
  logic [DW-1:0]    ent_q [DEPTH];
  logic [DEPTH-1:0] ent_we;
  logic [DW-1:0]    ent_wd;
  logic [PW-1:0]    fill_idx;
  logic [PW-1:0]    top_idx;
  logic [PW-1:0]    below_idx;

  assign fill_idx  = PW'(cnt_q);
  assign top_idx   = PW'(cnt_q - CW'(1));
  assign below_idx = PW'(cnt_q - CW'(2));

  assign top_q   = ent_q[top_idx];
  assign below_q = ent_q[below_idx];
  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign has_two = (cnt_q >= CW'(2));

  assign ent_wd = push_en ? push_data : bin_data;

  // per-entry write enable: a push fills the slot above the top,
  // a binary operation overwrites the slot below the top
  for (genvar g = 0; g < DEPTH; g++) begin : g_we
    assign ent_we[g] = (push_en && (fill_idx == PW'(g))) ||
                       (bin_en && (below_idx == PW'(g)));
  end

  always_comb begin
    cnt_d = cnt_q;
    if (push_en)               cnt_d = cnt_q + CW'(1);
    else if (pop_en || bin_en) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // data storage carries no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_we[i]) ent_q[i] <= ent_wd;
    end
  end
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       instr_valid,
  input  logic [1:0] instr_op,
  input  logic       empty,
  input  logic       full,
  input  logic       has_two,
  output logic       instr_ready,
  output logic       mem_rd_en,
  output logic       mem_wr_en,
  output logic       push_en,
  output logic       pop_en,
  output logic       bin_en,
  output logic       bin_mul,
  output logic       overflow_err,
  output logic       underflow_err
);
  stk_state_e state_q, state_d;
  logic       ovf_q, ovf_d;
  logic       unf_q, unf_d;
  logic       accept;
  logic       is_push, is_pop, is_bin;

  assign instr_ready = (state_q == ST_IDLE);
  assign accept      = instr_valid && instr_ready;
  assign is_push     = (instr_op == OP_PUSH);
  assign is_pop      = (instr_op == OP_POP);
  assign is_bin      = instr_op[1];

  assign mem_rd_en = accept && is_push && !full;
  assign mem_wr_en = accept && is_pop && !empty;
  assign pop_en    = mem_wr_en;
  assign bin_en    = accept && is_bin && has_two;
  assign bin_mul   = (instr_op == OP_MUL);
  assign push_en   = (state_q == ST_FILL);

  always_comb begin
    state_d = ST_IDLE;
    if (mem_rd_en) state_d = ST_FILL;
    ovf_d = ovf_q;
    unf_d = unf_q;
    if (accept && is_push && full) ovf_d = 1'b1;
    if (accept && ((is_pop && empty) || (is_bin && !has_two))) unf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ovf_q   <= ovf_d;
      unf_q   <= unf_d;
    end
  end

  assign overflow_err  = ovf_q;
  assign underflow_err = unf_q;
endmodule

// File: rtl/stack_eval.sv
module stack_eval #(
  parameter int DW    = 16,
  parameter int AW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  output logic          instr_ready,
  input  logic [1:0]    instr_op,
  input  logic [AW-1:0] instr_addr,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          overflow_err,
  output logic          underflow_err
);
  logic          push_en, pop_en, bin_en, bin_mul;
  logic          empty, full, has_two;
  logic [DW-1:0] top_q, below_q, alu_res;

  stk_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_valid   (instr_valid),
    .instr_op      (instr_op),
    .empty         (empty),
    .full          (full),
    .has_two       (has_two),
    .instr_ready   (instr_ready),
    .mem_rd_en     (mem_rd_en),
    .mem_wr_en     (mem_wr_en),
    .push_en       (push_en),
    .pop_en        (pop_en),
    .bin_en        (bin_en),
    .bin_mul       (bin_mul),
    .overflow_err  (overflow_err),
    .underflow_err (underflow_err)
  );

  stk_regs #(.DW(DW), .DEPTH(DEPTH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (push_en),
    .push_data (mem_rdata),
    .pop_en    (pop_en),
    .bin_en    (bin_en),
    .bin_data  (alu_res),
    .top_q     (top_q),
    .below_q   (below_q),
    .empty     (empty),
    .full      (full),
    .has_two   (has_two)
  );

  stk_alu #(.DW(DW)) u_alu (
    .below_i (below_q),
    .top_i   (top_q),
    .mul_i   (bin_mul),
    .res_o   (alu_res)
  );

  assign mem_addr  = instr_addr;
  assign mem_wdata = top_q;
endmodule

// File: rtl/stack_eval_chk.sv
module stack_eval_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       instr_valid,
  input logic       instr_ready,
  input logic [1:0] instr_op,
  input logic       mem_rd_en,
  input logic       mem_wr_en,
  input logic       overflow_err,
  input logic       underflow_err
);
  logic acc_w;
  assign acc_w = instr_valid && instr_ready;

  assert_rd_wr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  assert_rd_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (acc_w && instr_op == 2'b00));

  assert_wr_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (acc_w && instr_op == 2'b01));

  assert_push_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !instr_ready);

  assert_ready_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_ready |=> instr_ready);

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |=> overflow_err);

  assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |=> underflow_err);

  assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow_err) |-> $past(acc_w && instr_op == 2'b00 && !mem_rd_en));

  assert_unf_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underflow_err) |-> $past(acc_w && instr_op != 2'b00 && !mem_wr_en));
endmodule

bind stack_eval stack_eval_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .instr_valid   (instr_valid),
  .instr_ready   (instr_ready),
  .instr_op      (instr_op),
  .mem_rd_en     (mem_rd_en),
  .mem_wr_en     (mem_wr_en),
  .overflow_err  (overflow_err),
  .underflow_err (underflow_err)
);

// File: tb/stack_eval_tb_top.sv
module stack_eval_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        instr_valid;
  logic        instr_ready;
  logic [1:0]  instr_op;
  logic [7:0]  instr_addr;
  logic        mem_rd_en, mem_wr_en;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        overflow_err, underflow_err;

  int checks = 0;
  int errors = 0;

  // model state
  logic [15:0] model_stk[$];
  bit          model_ovf, model_unf;
  logic [7:0]  exp_rd_addr[$];
  logic [7:0]  exp_wr_addr[$];
  logic [15:0] exp_wr_data[$];
  string       exp_wr_tag[$];

  stack_eval dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_valid   (instr_valid),
    .instr_ready   (instr_ready),
    .instr_op      (instr_op),
    .instr_addr    (instr_addr),
    .mem_rd_en     (mem_rd_en),
    .mem_wr_en     (mem_wr_en),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rdata     (mem_rdata),
    .overflow_err  (overflow_err),
    .underflow_err (underflow_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [15:0] mem_val(input logic [7:0] a);
    return 16'(a) * 16'd4099 + 16'h0311;
  endfunction

  // synchronous memory model, one-cycle read latency
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem_val(mem_addr);
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // scoreboard monitor: memory strobes against expected queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd_en) begin
        if (exp_rd_addr.size() == 0) begin
          chk(0, "R7", "unexpected memory read", 1, 0);
        end else begin
          logic [7:0] ea;
          ea = exp_rd_addr.pop_front();
          chk(mem_addr == ea, "R2", "read address", mem_addr, ea);
        end
      end
      if (mem_wr_en) begin
        if (exp_wr_addr.size() == 0) begin
          chk(0, "R8", "unexpected memory write", 1, 0);
        end else begin
          logic [7:0]  wa;
          logic [15:0] wd;
          string       wt;
          wa = exp_wr_addr.pop_front();
          wd = exp_wr_data.pop_front();
          wt = exp_wr_tag.pop_front();
          chk(mem_addr == wa, wt, "write address", mem_addr, wa);
          chk(mem_wdata == wd, wt, "write data", mem_wdata, wd);
        end
      end
    end
  end

  // driver: predicts outcome, issues one instruction, checks handshake and flags
  task automatic issue(input logic [1:0] op, input logic [7:0] addr, input string tag);
    bit stall;
    stall = 0;
    case (op)
      2'b00: if (model_stk.size() == 8) model_ovf = 1;
             else begin
               exp_rd_addr.push_back(addr);
               model_stk.push_back(mem_val(addr));
               stall = 1;
             end
      2'b01: if (model_stk.size() == 0) model_unf = 1;
             else begin
               exp_wr_addr.push_back(addr);
               exp_wr_data.push_back(model_stk.pop_back());
               exp_wr_tag.push_back(tag);
             end
      default: if (model_stk.size() < 2) model_unf = 1;
             else begin
               logic [15:0] t, b;
               logic [31:0] p;
               t = model_stk.pop_back();
               b = model_stk.pop_back();
               p = 32'(b) * 32'(t);
               model_stk.push_back(op == 2'b10 ? 16'((32'(b) + 32'(t)) % 65536)
                                                : p[15:0]);
             end
    endcase
    @(posedge clk); #1;
    while (!instr_ready) begin @(posedge clk); #1; end
    instr_valid = 1'b1;
    instr_op    = op;
    instr_addr  = addr;
    @(posedge clk); #1;
    instr_valid = 1'b0;
    @(negedge clk);
    chk(instr_ready == !stall, stall ? "R2" : tag, "ready after accept",
        instr_ready, !stall);
    chk(overflow_err == model_ovf, tag, "overflow flag", overflow_err, model_ovf);
    chk(underflow_err == model_unf, tag, "underflow flag", underflow_err, model_unf);
  endtask

  task automatic do_reset();
    instr_valid = 1'b0;
    rst_n = 1'b0;
    model_stk.delete();
    model_ovf = 0;
    model_unf = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(instr_ready == 1'b1, "R1", "ready in reset", instr_ready, 1);
    chk(overflow_err == 1'b0, "R1", "overflow in reset", overflow_err, 0);
    chk(underflow_err == 1'b0, "R1", "underflow in reset", underflow_err, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    instr_op   = 2'b00;
    instr_addr = 8'h00;
    do_reset();

    // R1: empty after reset, first pop underflows
    issue(2'b01, 8'h10, "R1");
    do_reset();

    // R2, R4, R3: push, push, add, pop
    issue(2'b00, 8'h03, "R2");
    issue(2'b00, 8'h04, "R2");
    issue(2'b10, 8'h00, "R4");
    issue(2'b01, 8'h20, "R4");

    // R5: multiply with truncation, then add wrapping
    issue(2'b00, 8'hC1, "R2");
    issue(2'b00, 8'h7E, "R2");
    issue(2'b11, 8'h00, "R5");
    issue(2'b00, 8'hF0, "R2");
    issue(2'b10, 8'h00, "R4");
    issue(2'b00, 8'h55, "R2");
    issue(2'b11, 8'h00, "R5");
    issue(2'b01, 8'h21, "R5");

    // R6: fill to eight, then R7: push on full is dropped
    for (int i = 0; i < 8; i++) issue(2'b00, 8'(i * 29 + 1), "R6");
    issue(2'b00, 8'hAA, "R7");
    issue(2'b00, 8'hAB, "R7");
    for (int i = 0; i < 8; i++) issue(2'b01, 8'(8'h40 + i), "R6");

    // R8: underflow cases leave the stack intact
    issue(2'b01, 8'h50, "R8");
    issue(2'b00, 8'h09, "R2");
    issue(2'b10, 8'h00, "R8");
    issue(2'b11, 8'h00, "R8");
    issue(2'b01, 8'h51, "R8");

    // R9: flags stay set through further legal traffic
    issue(2'b00, 8'h11, "R9");
    issue(2'b00, 8'h12, "R9");
    issue(2'b11, 8'h00, "R9");
    issue(2'b01, 8'h60, "R9");

    // R10: back-to-back pop after push, strobes one at a time
    issue(2'b00, 8'h33, "R10");
    issue(2'b01, 8'h61, "R10");

    // R1: reset clears sticky flags
    @(posedge clk); #1;
    do_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(exp_rd_addr.size() == 0, "R2", "pending reads", exp_rd_addr.size(), 0);
    chk(exp_wr_addr.size() == 0, "R3", "pending writes", exp_wr_addr.size(), 0);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end
endmodule